// File: doc/BRIEF.md
# Two-Leaf Interleaved DRAM Controller

This controller sits between a 32-bit processor-style bus and DRAM that is split into two 32-bit banks, called leaves A and B. The bus starts an access with an address strobe together with a DRAM select decode. It then takes one data beat per READY, with a burst-last flag on the final beat. The controller opens the row with RAS. It then steers CAS to one leaf per beat, switching leaves on every beat. Because the two leaves are used in turn, only the first beat of a read burst pays the access penalty. Later read beats complete on every clock. Writes take two clocks per beat after the first.

A free-running interval counter raises a refresh request. The request is serviced as soon as the controller is idle, using CAS-before-RAS on both leaves at once. An access that collides with a refresh is held and started as soon as the refresh ends. A slow DMA master can stretch a single-beat read by holding an extend input. The controller then keeps READY and CAS active until extend drops.

Top module: `dram_leaf_ctrl`

## Requirements
- R1: While reset is held, ready is low, ras_n and dram_we_n are high, and both CAS groups are all ones.
- R2: In idle, ads with dram_sel high drives ras_n low in the next clock, and the first READY comes in the clock after that. ads with dram_sel low starts nothing.
- R3: A read beat after the first takes one clock, with READY high in consecutive clocks. The access ends at the READY clock in which blast is high. In the following clock ras_n is high and ready is low.
- R4: leaf_addr gives the starting leaf (0 = leaf A, 1 = leaf B). bank_sel shows the leaf of the current beat (0 = A) and alternates on every beat.
- R5: In every READY clock, the CAS group of the current leaf equals ~be (bit i belongs to byte lane i), and the other group is all ones.
- R6: A write has its first READY at the same point as a read. Each later write beat takes two clocks: a gap clock with ready low and both CAS groups all ones, then the READY clock. dram_we_n is low in the READY clocks of a write and high in those of a read.
- R7: A refresh request is raised every REF_INTERVAL clocks, the first one REF_INTERVAL clocks after reset. It is taken at the first idle clock.
- R8: A refresh lasts REF_CYCLES clocks, with ready low and both CAS groups all zeros. ras_n is high in the first of these clocks and low in the rest.
- R9: An ads that arrives while a refresh request is pending in idle delays the first READY by REF_CYCLES clocks. An ads that arrives during a refresh is held, and its RAS clock directly follows the last refresh clock. REF_CYCLES lies between 2 and 10.
- R10: On a single-beat read (blast high on the first beat), each READY clock with extend high is followed by another READY clock with the same leaf and CAS. The read ends at the first READY clock with extend low.
- R11: extend has no effect on writes or on read bursts of more than one beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ads | input | 1 | Address strobe, one clock per access |
| dram_sel | input | 1 | DRAM region decode qualifying ads |
| wr | input | 1 | 1 = write access, 0 = read access |
| leaf_addr | input | 1 | Address bit 2, picks the starting leaf |
| be | input | BE_W | Byte lane enables, active high |
| blast | input | 1 | Last beat of the access |
| extend | input | 1 | Stretch request for single-beat reads |
| ready | output | 1 | Beat completes this clock |
| bank_sel | output | 1 | Leaf of the current beat, 0 = A |
| ras_n | output | 1 | Row strobe, shared by both leaves |
| cas_a_n | output | BE_W | Column strobes of leaf A, per byte lane |
| cas_b_n | output | BE_W | Column strobes of leaf B, per byte lane |
| dram_we_n | output | 1 | DRAM write enable, active low |

## Verification
The bench builds the controller with REF_INTERVAL = 40 and REF_CYCLES = 6. A refresh request then falls every few accesses of random traffic. This brings three cases within reach: a request that arrives while a burst is running, one that is pending at the strobe, and a strobe that lands inside a running refresh at every remaining depth. With six refresh clocks, the CAS-before-RAS pattern can be seen in both its RAS-high and RAS-low phases, and the collision delay stays inside the ten-clock bound.

// File: rtl/dram_leaf_ctrl.sv
module dram_leaf_ctrl #(
  parameter int REF_INTERVAL = 390,
  parameter int REF_CYCLES   = 6,
  parameter int BE_W         = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ads,
  input  logic            dram_sel,
  input  logic            wr,
  input  logic            leaf_addr,
  input  logic [BE_W-1:0] be,
  input  logic            blast,
  input  logic            extend,
  output logic            ready,
  output logic            bank_sel,
  output logic            ras_n,
  output logic [BE_W-1:0] cas_a_n,
  output logic [BE_W-1:0] cas_b_n,
  output logic            dram_we_n
);
  localparam int RIW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
  localparam int RLW = (REF_CYCLES > 1) ? $clog2(REF_CYCLES) : 1;
  localparam logic [RIW-1:0] RI_LAST  = RIW'(REF_INTERVAL - 1);
  localparam logic [RLW-1:0] RL_FIRST = RLW'(REF_CYCLES - 1);

  typedef enum logic [2:0] {S_IDLE, S_RAS, S_RD, S_WR, S_WGAP, S_REF} st_t;

  st_t            st, st_n;
  logic [RIW-1:0] ref_cnt;
  logic [RLW-1:0] ref_left;
  logic           ref_pend, req_q, wr_q, a2_q, leaf, first;

  wire take     = ads & dram_sel;
  wire open_win = (st == S_IDLE) || (st == S_REF);
  wire ref_go   = (st == S_IDLE) && ref_pend;
  wire hold_ext = (st == S_RD) && first && blast && extend;
  wire cas_on   = (st == S_RD) || (st == S_WR);

  always_comb begin
    st_n = st;
    unique case (st)
      S_IDLE:  if (ref_pend) st_n = S_REF; else if (take) st_n = S_RAS;
      S_RAS:   st_n = wr_q ? S_WR : S_RD;
      S_RD:    if (blast && !hold_ext) st_n = S_IDLE;
      S_WR:    st_n = blast ? S_IDLE : S_WGAP;
      S_WGAP:  st_n = S_WR;
      S_REF:   if (ref_left == '0) st_n = (req_q || take) ? S_RAS : S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ref_cnt  <= '0;
      ref_pend <= 1'b0;
      ref_left <= '0;
      req_q    <= 1'b0;
      wr_q     <= 1'b0;
      a2_q     <= 1'b0;
      leaf     <= 1'b0;
      first    <= 1'b0;
    end else begin
      st <= st_n;
      if (ref_cnt == RI_LAST) ref_cnt <= '0;
      else ref_cnt <= ref_cnt + 1'b1;
      if (ref_cnt == RI_LAST) ref_pend <= 1'b1;
      else if (ref_go) ref_pend <= 1'b0;
      if (ref_go) ref_left <= RL_FIRST;
      else if (st == S_REF && ref_left != '0) ref_left <= ref_left - 1'b1;
      if (st == S_RAS) req_q <= 1'b0;
      else if (take && open_win) req_q <= 1'b1;
      if (take && open_win) begin
        wr_q <= wr;
        a2_q <= leaf_addr;
      end
      if (st == S_RAS) begin
        leaf  <= a2_q;
        first <= 1'b1;
      end else if (cas_on) begin
        leaf  <= hold_ext ? leaf : ~leaf;
        first <= hold_ext;
      end
    end
  end

  assign ready     = cas_on;
  assign bank_sel  = leaf;
  assign ras_n     = !((st == S_RAS) || (st == S_RD) || (st == S_WR) || (st == S_WGAP) ||
                       ((st == S_REF) && (ref_left != RL_FIRST)));
  assign cas_a_n   = (st == S_REF) ? '0 : (cas_on && !leaf) ? ~be : '1;
  assign cas_b_n   = (st == S_REF) ? '0 : (cas_on &&  leaf) ? ~be : '1;
  assign dram_we_n = !(wr_q && ((st == S_RAS) || (st == S_WR) || (st == S_WGAP)));
endmodule

// File: rtl/dram_leaf_ctrl_chk.sv
module dram_leaf_ctrl_chk #(
  parameter int BE_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ready,
  input logic            blast,
  input logic            extend,
  input logic            bank_sel,
  input logic            ras_n,
  input logic            dram_we_n,
  input logic [BE_W-1:0] cas_a_n,
  input logic [BE_W-1:0] cas_b_n
);
  a_r3_ready_inside_row: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !ras_n);

  a_r3_close_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && blast && !extend) |=> (!ready && ras_n));

  a_r4_leaf_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !blast) |=> (bank_sel != $past(bank_sel)));

  a_r5_one_leaf_per_beat: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> ((&cas_a_n) || (&cas_b_n)));

  a_r6_we_inside_row: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> !ras_n);

  a_r8_refresh_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ((cas_a_n == '0) && (cas_b_n == '0)) |-> !ready);
endmodule

bind dram_leaf_ctrl dram_leaf_ctrl_chk #(.BE_W(BE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ready(ready), .blast(blast), .extend(extend),
  .bank_sel(bank_sel), .ras_n(ras_n), .dram_we_n(dram_we_n),
  .cas_a_n(cas_a_n), .cas_b_n(cas_b_n)
);

// File: tb/dram_leaf_ctrl_tb_top.sv
module dram_leaf_ctrl_tb_top;
  localparam int RI = 40;
  localparam int RC = 6;
  localparam int BW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          ads = 0, dram_sel = 0, wr = 0, leaf_addr = 0, blast = 0, extend = 0;
  logic [BW-1:0] be = '0;
  logic          ready, bank_sel, ras_n, dram_we_n;
  logic [BW-1:0] cas_a_n, cas_b_n;

  dram_leaf_ctrl #(.REF_INTERVAL(RI), .REF_CYCLES(RC), .BE_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ads(ads), .dram_sel(dram_sel), .wr(wr),
    .leaf_addr(leaf_addr), .be(be), .blast(blast), .extend(extend),
    .ready(ready), .bank_sel(bank_sel), .ras_n(ras_n),
    .cas_a_n(cas_a_n), .cas_b_n(cas_b_n), .dram_we_n(dram_we_n)
  );

  int n_chk = 0, n_fail = 0;
  int m_cnt = 0, m_rleft = 0;
  bit m_pend = 0, done = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] cas_exp(bit leaf, bit want, logic [BW-1:0] b);
    return (leaf == want) ? ~b : '1;
  endfunction

  // one clock edge; model of refresh request (R7) and refresh occupancy (R8)
  task automatic step(bit ctl_idle, bit nxt_idle);
    bit start;
    start = (m_rleft == 0) && ctl_idle && m_pend;
    if (start) m_rleft = RC;
    else if (m_rleft > 0) m_rleft--;
    if (m_cnt == RI - 1) begin m_cnt = 0; m_pend = 1; end
    else begin m_cnt++; if (start) m_pend = 0; end
    @(negedge clk);
    if (m_rleft == RC) begin
      chk("R7", "refresh start ras_n", ras_n, 1);
      chk("R8", "refresh cas_a_n", cas_a_n, '0);
      chk("R8", "refresh cas_b_n", cas_b_n, '0);
    end else if (m_rleft > 0) begin
      chk("R8", "refresh ras_n", ras_n, 0);
      chk("R8", "refresh cas both", {cas_a_n, cas_b_n}, '0);
      chk("R8", "refresh ready", ready, 0);
    end else if (nxt_idle) begin
      chk("R3", "idle ras_n", ras_n, 1);
      chk("R3", "idle ready", ready, 0);
      chk("R7", "idle cas", {cas_a_n, cas_b_n}, {2*BW{1'b1}});
    end
  endtask

  task automatic idle1(bit stray);
    ads = stray; dram_sel = 0;
    step(1, 1);
    ads = 0;
    if (stray && m_rleft == 0) chk("R2", "unselected ads ignored", ras_n, 1);
  endtask

  task automatic txn(bit w, bit a2, int nb, logic [BW-1:0] b, int ext_len);
    int extra;
    bit ext_on, lf;
    extra  = (m_rleft > 0) ? m_rleft - 1 : (m_pend ? RC : 0);
    ext_on = !w && nb == 1 && ext_len > 0;
    ads = 1; dram_sel = 1; wr = w; leaf_addr = a2; be = b;
    blast = (nb == 1); extend = (ext_len > 0);
    step(1, 0);
    ads = 0; dram_sel = 0; wr = $urandom_range(1); leaf_addr = $urandom_range(1);
    for (int k = 0; k < extra; k++) begin
      chk("R9", "ready held by refresh", ready, 0);
      step(0, 0);
    end
    chk("R2", "row open before first beat", ras_n, 0);
    chk("R2", "no ready in RAS clock", ready, 0);
    step(0, 0);
    for (int i = 0; i < nb; i++) begin
      if (w && i > 0) begin
        chk("R6", "write gap ready", ready, 0);
        chk("R6", "write gap cas", {cas_a_n, cas_b_n}, {2*BW{1'b1}});
        step(0, 0);
      end
      blast = (i == nb - 1);
      lf = a2 ^ i[0];
      chk(ext_len > 0 ? "R11" : "R3", "beat ready", ready, 1);
      chk("R4", "bank_sel", bank_sel, lf);
      chk("R5", "cas_a_n", cas_a_n, cas_exp(lf, 0, b));
      chk("R5", "cas_b_n", cas_b_n, cas_exp(lf, 1, b));
      chk("R6", "dram_we_n", dram_we_n, !w);
      if (i == 0 && ext_on) begin
        for (int e = 0; e < ext_len; e++) begin
          step(0, 0);
          chk("R10", "extended ready", ready, 1);
          chk("R10", "extended leaf", bank_sel, lf);
          chk("R10", "extended cas", {cas_b_n, cas_a_n},
              {cas_exp(lf, 1, b), cas_exp(lf, 0, b)});
        end
        extend = 0;
      end
      if (i == nb - 1) begin
        step(0, 1);
        chk("R3", "closed after blast", {ready, ras_n}, 2'b01);
      end else step(0, 0);
    end
    blast = 0; extend = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0960_5eed));
    repeat (3) @(negedge clk);
    chk("R1", "reset ready", ready, 0);
    chk("R1", "reset ras_n", ras_n, 1);
    chk("R1", "reset we_n", dram_we_n, 1);
    chk("R1", "reset cas", {cas_a_n, cas_b_n}, {2*BW{1'b1}});
    rst_n = 1;

    txn(0, 0, 4, 4'hF, 0);
    txn(0, 1, 4, 4'hF, 0);
    txn(1, 0, 4, 4'h3, 0);
    txn(1, 1, 1, 4'hC, 0);
    idle1(1);
    txn(0, 0, 1, 4'hF, 3);
    txn(1, 0, 1, 4'hF, 2);
    txn(0, 1, 3, 4'h5, 2);
    while (!(m_pend && m_rleft == 0)) idle1(0);
    txn(0, 1, 2, 4'hF, 0);
    while (m_rleft != 3) idle1(0);
    txn(1, 0, 2, 4'hA, 0);
    while (m_rleft != 1) idle1(0);
    txn(0, 0, 4, 4'hF, 0);

    for (int n = 0; n < 200; n++) begin
      int gap;
      gap = $urandom_range(4);
      for (int g = 0; g < gap; g++) idle1($urandom_range(3) == 0);
      txn($urandom_range(1), $urandom_range(1), $urandom_range(1, 4),
          BW'($urandom_range(1, (1 << BW) - 1)),
          ($urandom_range(3) == 0) ? $urandom_range(1, 3) : 0);
    end
    idle1(0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule